// File: doc/BRIEF.md
# Two-Bank GPIO Controller with Half-Bank Edge Interrupts

This block is a register-mapped general-purpose I/O controller with two banks of 32 pins each. Every pin can be set as an input or an output. Software changes the output levels and the two edge-enable masks only through paired set and clear alias registers. This lets one pin change without a read-modify-write of the whole bank. Software can read each pin's actual level back through a synchronizer, whether the pin is driving or not.

Every pin can flag a rising edge, a falling edge, or both, into a sticky status bit. Software clears a status bit by writing 1 to it. The status bits are gathered in groups of 16 pins, so there are two groups per bank. Each group drives one level interrupt line. A separate group-enable register gates each line. The register port is synchronous: a write takes effect at the clock edge where it is presented, and read data appears one cycle after the address.

Top module: `banked_pio`

## Requirements
- R1: A direction bit of 1 makes the pin an input, so its `pinOe` bit is 0. A direction bit of 0 makes it an output, so `pinOe` is 1. A write to the direction register takes effect at the next clock edge.
- R2: The output latch drives `pinOut`. A write to the set-data alias sets every latch bit written as 1, and a write to the clear-data alias clears every bit written as 1; bits written as 0 are unchanged. Writes to the output-data register and to the input-data register change nothing.
- R3: The input-data register returns the pin level after a two-flop synchronizer, regardless of direction. After a pin changes, a read whose address is presented in the same cycle still returns the old level for two cycles and the new level from the third.
- R4: Each of the rising-enable and falling-enable masks has its own set alias and clear alias, both acting on bits written as 1. Reading any set or clear alias returns the current value of the register it controls. Both edges may be enabled on one pin.
- R5: A status bit becomes 1 three cycles after its pin changes, provided the matching edge enable is set. This holds for outputs as well as inputs. A pin with both enables set flags both directions.
- R6: Writing 1 to a status bit clears it, and writing 0 does nothing. No status bit falls without a write. When a new edge and a clear of the same bit arrive in the same cycle, the bit stays 1.
- R7: Interrupt line g is high exactly when group-enable bit g is 1 and any status bit of pins 16*g to 16*g+15 is 1. Bank 0 holds pins 0 to 31 and bank 1 holds pins 32 to 63. A group whose enable bit is 0 never asserts its line.
- R8: Address map, byte offsets with 4-byte words. The group-enable register is at 0x08, with bit g for group g. Bank b starts at 0x10 + 0x28*b. Its words are, in order: direction, output data, set data, clear data, input data, set rising, clear rising, set falling, clear falling, status.
- R9: After reset, all direction bits are 1, and the output latch, both edge masks, all status bits and all group enables are 0.
- R10: Read data is registered: it reflects the register state one cycle after the address is presented. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Write strobe for the register port |
| regAddr | input | 8 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| pinIn | input | 64 | Pad input levels, asynchronous |
| pinOut | output | 64 | Output latch levels |
| pinOe | output | 64 | Output enable, 1 = driving |
| grpIrq | output | 4 | Level interrupt, one per 16-pin group |

## Verification
The hardest case to reach from the ports is a new edge landing on a status bit in the same clock cycle as a software clear of that bit. It is hard because the edge arrives three cycles after the pin moves. The bench reaches it with a directed sequence. It arms a rising enable, gets the bit set once, and drops the pin. It then raises the pin again and issues the write-1-to-clear exactly two cycles later, so that both land together. The same directed style checks the two-cycle stale window on input readback. Random traffic over all registers, pin changes and group enables covers the rest against a bench-side model.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Word index inside one bank's register window
  typedef enum logic [3:0] {
    REG_DIR  = 4'd0,
    REG_OUT  = 4'd1,
    REG_SET  = 4'd2,
    REG_CLR  = 4'd3,
    REG_IN   = 4'd4,
    REG_SETR = 4'd5,
    REG_CLRR = 4'd6,
    REG_SETF = 4'd7,
    REG_CLRF = 4'd8,
    REG_STAT = 4'd9
  } regIdx_e;

  localparam int REGS_PER_BANK = 10;

  // Write strobes handed from control to datapath, one set per bank
  typedef struct packed {
    logic wrDir;
    logic setOut;
    logic clrOut;
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic clrStat;
  } bankStb_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_BANKS   = 2,
  parameter int BANK_BASE   = 'h10,
  parameter int BANK_STRIDE = 'h28,
  parameter int GRPEN_ADDR  = 'h08
) (
  input  logic                  regWe,
  input  logic [ADDR_W-1:0]     regAddr,
  output bankStb_t              bankStb [NUM_BANKS],
  output logic                  wrGrpEn,
  output logic                  rdGrpEn,
  output logic                  rdBankHit,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] rdBank,
  output regIdx_e               rdReg
);

  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int WIN_BYTES  = REGS_PER_BANK * 4;

  logic    bankHit [NUM_BANKS];
  regIdx_e bankIdx [NUM_BANKS];

  assign rdGrpEn = (regAddr == ADDR_W'(GRPEN_ADDR));
  assign wrGrpEn = regWe && rdGrpEn;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    localparam int LO = BANK_BASE + b * BANK_STRIDE;
    logic [ADDR_W-1:0] off;
    logic              we;

    assign off        = regAddr - ADDR_W'(LO);
    assign bankHit[b] = (regAddr >= ADDR_W'(LO)) && (off < ADDR_W'(WIN_BYTES))
                        && (regAddr[1:0] == 2'b00);
    assign bankIdx[b] = regIdx_e'(off[5:2]);
    assign we         = regWe && bankHit[b];

    always_comb begin
      bankStb[b] = '0;
      if (we) begin
        case (bankIdx[b])
          REG_DIR:  bankStb[b].wrDir   = 1'b1;
          REG_SET:  bankStb[b].setOut  = 1'b1;
          REG_CLR:  bankStb[b].clrOut  = 1'b1;
          REG_SETR: bankStb[b].setRise = 1'b1;
          REG_CLRR: bankStb[b].clrRise = 1'b1;
          REG_SETF: bankStb[b].setFall = 1'b1;
          REG_CLRF: bankStb[b].clrFall = 1'b1;
          REG_STAT: bankStb[b].clrStat = 1'b1;
          default:  bankStb[b] = '0;
        endcase
      end
    end
  end

  always_comb begin
    rdBankHit = 1'b0;
    rdBank    = '0;
    rdReg     = REG_DIR;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankHit[b]) begin
        rdBankHit = 1'b1;
        rdBank    = BANK_SEL_W'(b);
        rdReg     = bankIdx[b];
      end
    end
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int GROUP_W   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bankStb_t                      bankStb [NUM_BANKS],
  input  logic                          wrGrpEn,
  input  logic                          rdGrpEn,
  input  logic                          rdBankHit,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] rdBank,
  input  regIdx_e                       rdReg,
  input  logic [BANK_W-1:0]             wrData,
  input  logic [NUM_BANKS*BANK_W-1:0]   pinIn,
  output logic [BANK_W-1:0]             rdData,
  output logic [NUM_BANKS*BANK_W-1:0]   pinOut,
  output logic [NUM_BANKS*BANK_W-1:0]   pinOe,
  output logic [NUM_BANKS*BANK_W/GROUP_W-1:0] grpIrq,
  output logic [NUM_BANKS*BANK_W-1:0]   statAll,
  output logic [NUM_BANKS*BANK_W/GROUP_W-1:0] grpEnQ
);

  localparam int NUM_PINS   = NUM_BANKS * BANK_W;
  localparam int NUM_GROUPS = NUM_PINS / GROUP_W;

  logic [NUM_BANKS-1:0][BANK_W-1:0] dirA, outA, riseA, fallA, statA, levelA;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dirQ, outQ, riseQ, fallQ, statQ;
    logic [BANK_W-1:0] syncA, syncB, prevQ, edgeHit;
    logic [BANK_W-1:0] maskW;
    bankStb_t          stb;

    assign stb     = bankStb[b];
    assign maskW   = wrData;
    assign edgeHit = (syncB & ~prevQ & riseQ) | (~syncB & prevQ & fallQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirQ  <= '1;
        outQ  <= '0;
        riseQ <= '0;
        fallQ <= '0;
        statQ <= '0;
        syncA <= '0;
        syncB <= '0;
        prevQ <= '0;
      end else begin
        syncA <= pinIn[b*BANK_W +: BANK_W];
        syncB <= syncA;
        prevQ <= syncB;
        if (stb.wrDir) dirQ <= maskW;
        if (stb.setOut)       outQ  <= outQ | maskW;
        else if (stb.clrOut)  outQ  <= outQ & ~maskW;
        if (stb.setRise)      riseQ <= riseQ | maskW;
        else if (stb.clrRise) riseQ <= riseQ & ~maskW;
        if (stb.setFall)      fallQ <= fallQ | maskW;
        else if (stb.clrFall) fallQ <= fallQ & ~maskW;
        // a fresh edge wins over a simultaneous clear
        statQ <= (statQ & ~(stb.clrStat ? maskW : '0)) | edgeHit;
      end
    end

    assign dirA[b]   = dirQ;
    assign outA[b]   = outQ;
    assign riseA[b]  = riseQ;
    assign fallA[b]  = fallQ;
    assign statA[b]  = statQ;
    assign levelA[b] = syncB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) grpEnQ <= '0;
    else if (wrGrpEn) grpEnQ <= wrData[NUM_GROUPS-1:0];
  end

  logic [BANK_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    if (rdGrpEn) begin
      rdNext = BANK_W'(grpEnQ);
    end else if (rdBankHit) begin
      case (rdReg)
        REG_DIR:                   rdNext = dirA[rdBank];
        REG_OUT, REG_SET, REG_CLR: rdNext = outA[rdBank];
        REG_IN:                    rdNext = levelA[rdBank];
        REG_SETR, REG_CLRR:        rdNext = riseA[rdBank];
        REG_SETF, REG_CLRF:        rdNext = fallA[rdBank];
        REG_STAT:                  rdNext = statA[rdBank];
        default:                   rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign statAll = statA;
  assign pinOut  = outA;
  assign pinOe   = ~dirA;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grpIrq[g] = grpEnQ[g] & (|statAll[g*GROUP_W +: GROUP_W]);
  end

endmodule

// File: rtl/banked_pio.sv
module banked_pio
  import pio_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int GROUP_W     = 16,
  parameter int BANK_BASE   = 'h10,
  parameter int BANK_STRIDE = 'h28,
  parameter int GRPEN_ADDR  = 'h08
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                regWe,
  input  logic [ADDR_W-1:0]                   regAddr,
  input  logic [BANK_W-1:0]                   regWdata,
  output logic [BANK_W-1:0]                   regRdata,
  input  logic [NUM_BANKS*BANK_W-1:0]         pinIn,
  output logic [NUM_BANKS*BANK_W-1:0]         pinOut,
  output logic [NUM_BANKS*BANK_W-1:0]         pinOe,
  output logic [NUM_BANKS*BANK_W/GROUP_W-1:0] grpIrq
);

  localparam int NUM_PINS   = NUM_BANKS * BANK_W;
  localparam int NUM_GROUPS = NUM_PINS / GROUP_W;
  localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  bankStb_t              bankStb [NUM_BANKS];
  logic                  wrGrpEn, rdGrpEn, rdBankHit;
  logic [BANK_SEL_W-1:0] rdBank;
  regIdx_e               rdReg;
  logic [NUM_PINS-1:0]   statAll;
  logic [NUM_GROUPS-1:0] grpEnQ;

  pio_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_BASE(BANK_BASE),
    .BANK_STRIDE(BANK_STRIDE), .GRPEN_ADDR(GRPEN_ADDR)
  ) uCtrl (
    .regWe(regWe), .regAddr(regAddr), .bankStb(bankStb),
    .wrGrpEn(wrGrpEn), .rdGrpEn(rdGrpEn), .rdBankHit(rdBankHit),
    .rdBank(rdBank), .rdReg(rdReg)
  );

  pio_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .GROUP_W(GROUP_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .bankStb(bankStb), .wrGrpEn(wrGrpEn),
    .rdGrpEn(rdGrpEn), .rdBankHit(rdBankHit), .rdBank(rdBank), .rdReg(rdReg),
    .wrData(regWdata), .pinIn(pinIn), .rdData(regRdata), .pinOut(pinOut),
    .pinOe(pinOe), .grpIrq(grpIrq), .statAll(statAll), .grpEnQ(grpEnQ)
  );

endmodule

// File: rtl/banked_pio_chk.sv
module banked_pio_chk #(
  parameter int ADDR_W     = 8,
  parameter int BANK_W     = 32,
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 4,
  parameter int BANK_BASE  = 'h10
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [BANK_W-1:0]     regWdata,
  input logic [NUM_PINS-1:0]   pinOut,
  input logic [NUM_PINS-1:0]   pinOe,
  input logic [NUM_GROUPS-1:0] grpIrq,
  input logic [NUM_PINS-1:0]   statAll,
  input logic [NUM_GROUPS-1:0] grpEnQ
);

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(BANK_BASE)) |=> (pinOe[BANK_W-1:0] == ~$past(regWdata))); // R1

  AST_SET_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(BANK_BASE + 8))
      |=> (pinOut[BANK_W-1:0] == ($past(pinOut[BANK_W-1:0]) | $past(regWdata)))); // R2

  AST_CLR_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(BANK_BASE + 12))
      |=> (pinOut[BANK_W-1:0] == ($past(pinOut[BANK_W-1:0]) & ~$past(regWdata)))); // R2

  AST_OUT_DIRECT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(BANK_BASE + 4)) |=> $stable(pinOut)); // R2

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |=> (($past(statAll) & ~statAll) == '0)); // R6

  AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    ((grpIrq & ~grpEnQ) == '0)); // R7

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(statAll) && $stable(grpEnQ)) |-> $stable(grpIrq)); // R7

endmodule

bind banked_pio banked_pio_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_PINS(NUM_PINS),
  .NUM_GROUPS(NUM_GROUPS), .BANK_BASE(BANK_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .pinOut(pinOut), .pinOe(pinOe), .grpIrq(grpIrq),
  .statAll(statAll), .grpEnQ(grpEnQ)
);

// File: tb/sim_banked_pio.sv
`timescale 1ns/1ps
module sim_banked_pio;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] pinIn = '0;
  logic [63:0] pinOut, pinOe;
  logic [3:0]  grpIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model
  logic [31:0] mDir [2];
  logic [31:0] mOut [2];
  logic [31:0] mRise[2];
  logic [31:0] mFall[2];
  logic [31:0] mStat[2];
  logic [3:0]  mGrp;
  logic [63:0] mPins;

  always #10 clk = ~clk;

  banked_pio u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .grpIrq(grpIrq)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mRead(input logic [7:0] a);
    if (a == 8'h08) return {28'd0, mGrp};
    for (int b = 0; b < 2; b++) begin
      int base = 'h10 + b * 'h28;
      if (a >= base && a < base + 40 && a[1:0] == 2'b00) begin
        case ((a - base) / 4)
          0: return mDir[b];
          1, 2, 3: return mOut[b];
          4: return mPins[b*32 +: 32];
          5, 6: return mRise[b];
          7, 8: return mFall[b];
          default: return mStat[b];
        endcase
      end
    end
    return 32'd0;
  endfunction

  task automatic mWrite(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h08) mGrp = d[3:0];
    for (int b = 0; b < 2; b++) begin
      int base = 'h10 + b * 'h28;
      if (a >= base && a < base + 40 && a[1:0] == 2'b00) begin
        case ((a - base) / 4)
          0: mDir[b]  = d;
          2: mOut[b]  = mOut[b] | d;
          3: mOut[b]  = mOut[b] & ~d;
          5: mRise[b] = mRise[b] | d;
          6: mRise[b] = mRise[b] & ~d;
          7: mFall[b] = mFall[b] | d;
          8: mFall[b] = mFall[b] & ~d;
          9: mStat[b] = mStat[b] & ~d;
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [3:0] mIrq();
    logic [63:0] s = {mStat[1], mStat[0]};
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = mGrp[g] & (|s[g*16 +: 16]);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWe = 1'b0;
    mWrite(a, d);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a);
    regAddr = a;
    tick();
    check(req, {32'd0, regRdata}, {32'd0, mRead(a)});
  endtask

  task automatic setPins(input logic [63:0] v);
    logic [63:0] rise, fall;
    pinIn = v;
    tick(); tick(); tick();
    rise = v & ~mPins & {mRise[1], mRise[0]};
    fall = ~v & mPins & {mFall[1], mFall[0]};
    mStat[0] = mStat[0] | rise[31:0] | fall[31:0];
    mStat[1] = mStat[1] | rise[63:32] | fall[63:32];
    mPins = v;
  endtask

  task automatic portsChk();
    check("R2 pinOut", pinOut, {mOut[1], mOut[0]});
    check("R1 pinOe", pinOe, ~{mDir[1], mDir[0]});
    check("R7 grpIrq", {60'd0, grpIrq}, {60'd0, mIrq()});
  endtask

  function automatic logic [7:0] randAddr();
    int r = $urandom % 24;
    if (r < 20) return 8'('h10 + (r / 10) * 'h28 + (r % 10) * 4);
    case (r)
      20: return 8'h08;
      21: return 8'h00;
      22: return 8'h04;
      default: return 8'h0C;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    for (int b = 0; b < 2; b++) begin
      mDir[b] = '1; mOut[b] = '0; mRise[b] = '0; mFall[b] = '0; mStat[b] = '0;
    end
    mGrp = '0; mPins = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R9: reset state
    check("R9 pinOe reset", pinOe, 64'd0);
    check("R9 pinOut reset", pinOut, 64'd0);
    check("R9 grpIrq reset", {60'd0, grpIrq}, 64'd0);
    rdChk("R9 dir reset", 8'h10);
    rdChk("R9 dir1 reset R8", 8'h38);

    // R1/R2: direction and set/clear aliases, direct writes ignored
    wr(8'h10, 32'h0000_FFFF);
    check("R1 direction", pinOe[31:0], 64'hFFFF_0000);
    wr(8'h18, 32'hA5A5_0F0F);
    wr(8'h1C, 32'h0000_0F00);
    check("R2 set/clear", pinOut[31:0], 64'hA5A5_000F);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    check("R2 direct write ignored", pinOut[31:0], 64'hA5A5_000F);
    rdChk("R4 set alias readback", 8'h18);
    rdChk("R2 input write ignored", 8'h20);

    // R3: readback latency and level visible on outputs
    regAddr = 8'h20;
    pinIn = 64'h0000_0000_1234_5678;
    tick();
    check("R3 stale 1", {32'd0, regRdata}, 64'd0);
    tick();
    check("R3 stale 2", {32'd0, regRdata}, 64'd0);
    tick();
    check("R3 new level", {32'd0, regRdata}, 64'h1234_5678);
    mPins = pinIn;
    setPins(64'd0);

    // R4/R5: both edges on one pin, outputs too
    wr(8'h24, 32'h0000_0001);
    wr(8'h2C, 32'h0000_0001);
    rdChk("R4 rise alias", 8'h28);
    rdChk("R4 fall alias", 8'h30);
    setPins(64'h1);
    rdChk("R5 rise flagged", 8'h34);
    wr(8'h34, 32'h1);
    setPins(64'h0);
    rdChk("R5 fall flagged", 8'h34);
    wr(8'h34, 32'h0);
    rdChk("R6 write 0 no effect", 8'h34);

    // R6: edge beats simultaneous clear
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h1);
    setPins(64'h1);
    setPins(64'h0);
    pinIn = 64'h1;
    tick(); tick();
    regWe = 1'b1; regAddr = 8'h34; regWdata = 32'h1;
    tick();
    regWe = 1'b0;
    mPins = 64'h1;
    rdChk("R6 edge beats clear", 8'h34);
    wr(8'h34, 32'h1);
    rdChk("R6 cleared", 8'h34);

    // R7: group gating, upper half of bank 0 and bank 1
    wr(8'h24, 32'hFFFF_0000);
    wr(8'h4C, 32'h0001_0000);
    setPins(64'h0001_0000_0001_0001);
    check("R7 gated off", {60'd0, grpIrq}, 64'd0);
    wr(8'h08, 32'h2);
    check("R7 group1 only", {60'd0, grpIrq}, 64'h2);
    wr(8'h08, 32'hF);
    check("R7 groups 1,3", {60'd0, grpIrq}, 64'hA);
    wr(8'h34, 32'hFFFF_FFFF);
    check("R7 after clear", {60'd0, grpIrq}, {60'd0, mIrq()});

    // R10: unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    rdChk("R10 unmapped 0C", 8'h0C);
    rdChk("R10 unmapped 60", 8'h60);
    rdChk("R8 group enable readback", 8'h08);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 100;
      if (op < 50) begin
        wr(randAddr(), $urandom);
      end else if (op < 80) begin
        rdChk("R8 random read", randAddr());
      end else begin
        setPins({$urandom, $urandom});
        rdChk("R5 random status b0", 8'h34);
        rdChk("R5 random status b1", 8'h5C);
      end
      portsChk();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule